// File: doc/BRIEF.md
# Floppy Controller Port Decoder

This block sits between the I/O space of an 8-bit processor and the register set of a single-chip floppy disk controller. It turns a port number and a read or write strobe into a select for one of the controller's registers: command/status, track, sector and data. It also selects a separate drive-control latch. The track, sector, data and drive-control values are held here, so a value written can be read back unchanged. Command execution is only a stub: a write to the command register makes the controller look busy for a fixed number of clock cycles.

The four controller registers take a block of four ports starting at a base that is 16-aligned. The same four registers answer again at the next four ports, as an exact alias. Driver code moves between the status and data ports by stepping the port number up or down, and it detects the card by reading back through the alias, so the alias has to behave exactly like the primary ports. The drive-control latch sits at base+8 and has no alias. A read from any other port leaves the bus idle: the block returns all ones and keeps its card-select low.

Top module: `fdc_port_decode`

## Requirements
- R1: After reset, the track, sector, data and drive-control registers read 00h, and the status register reads 00h (not busy).
- R2: A write to base+1 sets the track register on the clock edge at which the write strobe is high. A read of base+1 then returns that value unchanged.
- R3: A write to base+2 sets the sector register. A read of base+2 then returns that value unchanged.
- R4: A write to base+3 stores a byte in the data register. A read of base+3 returns that byte.
- R5: Ports base+4..base+7 are exact aliases of base+0..base+3, both for reads and for writes. For example, at base 10h a write to 16h is read back at 12h, and a write to 11h is read back at 15h.
- R6: Reads have no side effects. Stepping back and forth between the data and status ports, through primary and alias addresses, leaves every value unchanged.
- R7: Card detection works in two rounds. In the first, 55h is written to the track register and AAh to the sector register, and the values are read back through the alias ports. In the second, the two values are swapped. Both rounds return the written values.
- R8: The drive-control latch at base+8 is written and read back. Ports base+9..base+15 are not decoded.
- R9: For any port outside base+0..base+8, a read returns FFh with card_sel low, and a write changes no register.
- R10: A write to the command register (base+0 or base+4) sets status bit 0 (busy) for exactly BUSY_CYCLES clock cycles after the write edge. All other status bits read 0.
- R11: The BASE_ADDR parameter moves the whole decoded range. An instance at 30h answers at 30h..38h and ignores 10h..18h.
- R12: card_sel is high only while a read or write strobe is active on a decoded port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_addr | input | ADDR_W | I/O port number |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data; all ones when no decoded port is read |
| card_sel | output | 1 | High while a strobe addresses a decoded port |

## Verification
The bench builds two copies of the block. The first uses the default base of 10h and a BUSY_CYCLES of 4. This makes the card-detect sequence at 11h/12h/15h/16h, the drive latch at 18h and the busy window cycle-countable. The second copy shares the same bus with BASE_ADDR set to 30h. That shows the range moves as a whole: each copy stays silent on ports that belong to the other.

// File: rtl/fdc_pd_pkg.sv
package fdc_pd_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_STAT = 3'd1,
    SEL_TRK  = 3'd2,
    SEL_SEC  = 3'd3,
    SEL_DAT  = 3'd4,
    SEL_DRV  = 3'd5
  } port_sel_e;

  localparam int unsigned NUM_STORE = 4;

endpackage

// File: rtl/fdc_addr_dec.sv
module fdc_addr_dec
  import fdc_pd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel
);

  // The controller window spans eight ports: four registers and their alias.
  localparam logic [ADDR_W-1:0] DRV_PORT = BASE_ADDR + ADDR_W'(8);
  localparam int unsigned       WIN_LSB  = 3;

  logic in_window;

  assign in_window = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);

  always_comb begin
    sel = SEL_NONE;
    if (in_window) begin
      // Bit 2 selects the alias half and is ignored.
      unique case (addr[1:0])
        2'd0:    sel = SEL_STAT;
        2'd1:    sel = SEL_TRK;
        2'd2:    sel = SEL_SEC;
        default: sel = SEL_DAT;
      endcase
    end else if (addr == DRV_PORT) begin
      sel = SEL_DRV;
    end
  end

endmodule

// File: rtl/fdc_reg_file.sv
module fdc_reg_file
  import fdc_pd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  port_sel_e         sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] trk_q,
  output logic [DATA_W-1:0] sec_q,
  output logic [DATA_W-1:0] dat_q,
  output logic [DATA_W-1:0] drv_q
);

  logic [NUM_STORE-1:0]             hit;
  logic [NUM_STORE-1:0][DATA_W-1:0] q;

  assign hit = {sel == SEL_DRV, sel == SEL_DAT, sel == SEL_SEC, sel == SEL_TRK};

  for (genvar g = 0; g < NUM_STORE; g++) begin : g_store
    logic              en;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] r;

    always_comb begin
      en  = wr_en && hit[g];
      nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (en) begin
        r <= nxt;
      end
    end

    assign q[g] = r;
  end

  assign trk_q = q[0];
  assign sec_q = q[1];
  assign dat_q = q[2];
  assign drv_q = q[3];

endmodule

// File: rtl/fdc_busy_stub.sv
module fdc_busy_stub #(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = start || (cnt_q != '0);
    cnt_nxt = start ? LOAD : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
  import fdc_pd_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h10,
  parameter int unsigned       BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              card_sel
);

  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_q = rst_sync_q[1];

  port_sel_e         sel;
  logic [DATA_W-1:0] trk_q;
  logic [DATA_W-1:0] sec_q;
  logic [DATA_W-1:0] dat_q;
  logic [DATA_W-1:0] drv_q;
  logic              busy;
  logic              cmd_wr;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rd_val;

  fdc_addr_dec #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(io_addr),
    .sel (sel)
  );

  fdc_reg_file #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_q),
    .wr_en(io_wr),
    .sel  (sel),
    .wdata(io_wdata),
    .trk_q(trk_q),
    .sec_q(sec_q),
    .dat_q(dat_q),
    .drv_q(drv_q)
  );

  assign cmd_wr = io_wr && (sel == SEL_STAT);

  fdc_busy_stub #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_busy (
    .clk  (clk),
    .rst_n(rst_q),
    .start(cmd_wr),
    .busy (busy)
  );

  assign status = {{(DATA_W-1){1'b0}}, busy};

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_val = status;
      SEL_TRK:  rd_val = trk_q;
      SEL_SEC:  rd_val = sec_q;
      SEL_DAT:  rd_val = dat_q;
      SEL_DRV:  rd_val = drv_q;
      default:  rd_val = '1;
    endcase
  end

  assign io_rdata = io_rd ? rd_val : '1;
  assign card_sel = (io_rd || io_wr) && (sel != SEL_NONE);

endmodule

// File: rtl/fdc_port_decode_chk.sv
module fdc_port_decode_chk #(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h10,
  parameter int unsigned       BUSY_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              card_sel,
  input logic [DATA_W-1:0] trk_q,
  input logic              busy
);

  localparam logic [ADDR_W-1:0] P_CMD  = BASE_ADDR;
  localparam logic [ADDR_W-1:0] P_TRK  = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] P_CMDM = BASE_ADDR + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] P_TRKM = BASE_ADDR + ADDR_W'(5);

  AST_IDLE_BUS_ONES: assert property (@(posedge clk) disable iff (!rst_n) (io_rd && !card_sel) |-> (io_rdata == '1)); // R9
  AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) card_sel |-> (io_rd || io_wr)); // R12
  AST_TRK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && (io_addr == P_TRK || io_addr == P_TRKM)) |=> (trk_q == $past(io_wdata))); // R2
  AST_TRK_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n) (io_rd && io_addr == P_TRKM) |-> (io_rdata == trk_q)); // R5
  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && (io_addr == P_CMD || io_addr == P_CMDM)) |=> busy); // R10
  AST_STATUS_BIT0: assert property (@(posedge clk) disable iff (!rst_n) (io_rd && (io_addr == P_CMD || io_addr == P_CMDM)) |-> (io_rdata == DATA_W'(busy))); // R10

endmodule

bind fdc_port_decode fdc_port_decode_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BASE_ADDR  (BASE_ADDR),
  .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .io_addr (io_addr),
  .io_rd   (io_rd),
  .io_wr   (io_wr),
  .io_wdata(io_wdata),
  .io_rdata(io_rdata),
  .card_sel(card_sel),
  .trk_q   (trk_q),
  .busy    (busy)
);

// File: tb/tb_fdc_port_decode.sv
module tb_fdc_port_decode;

  localparam int BUSY_N = 4;

  logic       clk;
  logic       rst_n;
  logic [7:0] io_addr;
  logic       io_rd;
  logic       io_wr;
  logic [7:0] io_wdata;
  logic [7:0] rdata_a;
  logic       sel_a;
  logic [7:0] rdata_b;
  logic       sel_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  fdc_port_decode #(.BASE_ADDR(8'h10), .BUSY_CYCLES(BUSY_N)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rdata_a), .card_sel(sel_a)
  );

  fdc_port_decode #(.BASE_ADDR(8'h30), .BUSY_CYCLES(BUSY_N)) dut_b30 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rdata_b), .card_sel(sel_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
    @(negedge clk);
    io_wr    = 1'b0;
  endtask

  // Combinational read at the current time, half a cycle away from an edge.
  task automatic peek(input logic [7:0] a, output logic [7:0] da, output logic sa,
                      output logic [7:0] db, output logic sb);
    io_addr = a;
    io_rd   = 1'b1;
    #1;
    da = rdata_a; sa = sel_a; db = rdata_b; sb = sel_b;
    io_rd   = 1'b0;
  endtask

  task automatic rd_a(input string req, input logic [7:0] a, input logic [7:0] exp, input logic exp_sel);
    logic [7:0] da, db;
    logic       sa, sb;
    @(negedge clk);
    peek(a, da, sa, db, sb);
    chk(req, da, exp);
    chk({req, " card_sel"}, {7'd0, sa}, {7'd0, exp_sel});
  endtask

  task automatic t_reset();
    rd_a("R1 status", 8'h10, 8'h00, 1'b1);
    rd_a("R1 track", 8'h11, 8'h00, 1'b1);
    rd_a("R1 sector", 8'h12, 8'h00, 1'b1);
    rd_a("R1 data", 8'h13, 8'h00, 1'b1);
    rd_a("R1 drive", 8'h18, 8'h00, 1'b1);
  endtask

  task automatic t_regs();
    wr_port(8'h11, 8'hA5);
    rd_a("R2 track", 8'h11, 8'hA5, 1'b1);
    wr_port(8'h12, 8'h3C);
    rd_a("R3 sector", 8'h12, 8'h3C, 1'b1);
    rd_a("R2 track kept", 8'h11, 8'hA5, 1'b1);
    wr_port(8'h13, 8'hC3);
    rd_a("R4 data", 8'h13, 8'hC3, 1'b1);
  endtask

  task automatic t_mirror();
    rd_a("R5 data alias", 8'h17, 8'hC3, 1'b1);
    wr_port(8'h16, 8'h5A);
    rd_a("R5 sector via alias", 8'h12, 8'h5A, 1'b1);
    wr_port(8'h17, 8'h69);
    rd_a("R5 data via alias", 8'h13, 8'h69, 1'b1);
    rd_a("R5 status alias", 8'h14, 8'h00, 1'b1);
  endtask

  task automatic t_step();
    for (int i = 0; i < 3; i++) begin
      rd_a("R6 data step", 8'h13, 8'h69, 1'b1);
      rd_a("R6 status step", 8'h10, 8'h00, 1'b1);
      rd_a("R6 data alias step", 8'h17, 8'h69, 1'b1);
      rd_a("R6 status alias step", 8'h14, 8'h00, 1'b1);
    end
    rd_a("R6 track intact", 8'h11, 8'hA5, 1'b1);
    rd_a("R6 sector intact", 8'h12, 8'h5A, 1'b1);
  endtask

  task automatic t_detect();
    wr_port(8'h11, 8'h55);
    wr_port(8'h12, 8'hAA);
    rd_a("R7 round1 track", 8'h15, 8'h55, 1'b1);
    rd_a("R7 round1 sector", 8'h16, 8'hAA, 1'b1);
    wr_port(8'h11, 8'hAA);
    wr_port(8'h12, 8'h55);
    rd_a("R7 round2 track", 8'h15, 8'hAA, 1'b1);
    rd_a("R7 round2 sector", 8'h16, 8'h55, 1'b1);
  endtask

  task automatic t_drive();
    wr_port(8'h18, 8'h81);
    rd_a("R8 drive latch", 8'h18, 8'h81, 1'b1);
    rd_a("R8 base+9 undecoded", 8'h19, 8'hFF, 1'b0);
    rd_a("R8 base+12 undecoded", 8'h1C, 8'hFF, 1'b0);
    wr_port(8'h1C, 8'h99);
    rd_a("R8 latch unaliased", 8'h18, 8'h81, 1'b1);
  endtask

  task automatic t_outside();
    logic [7:0] da, db;
    logic       sa, sb;
    wr_port(8'h40, 8'hEE);
    wr_port(8'h0F, 8'hEE);
    wr_port(8'h09, 8'hEE);
    rd_a("R9 read outside", 8'h40, 8'hFF, 1'b0);
    rd_a("R9 read below base", 8'h0F, 8'hFF, 1'b0);
    rd_a("R9 track untouched", 8'h11, 8'hAA, 1'b1);
    rd_a("R9 sector untouched", 8'h12, 8'h55, 1'b1);
    rd_a("R9 data untouched", 8'h13, 8'h69, 1'b1);
    rd_a("R9 drive untouched", 8'h18, 8'h81, 1'b1);
    @(negedge clk);
    io_addr = 8'h11;
    #1;
    da = rdata_a; sa = sel_a;
    chk("R12 no strobe card_sel", {7'd0, sa}, 8'h00);
    chk("R12 no strobe rdata", da, 8'hFF);
    peek(8'h11, da, sa, db, sb);
    chk("R12 read strobe card_sel", {7'd0, sa}, 8'h01);
  endtask

  task automatic t_busy();
    logic [7:0] da, db;
    logic       sa, sb;
    wr_port(8'h14, 8'h08);
    for (int i = 0; i < BUSY_N; i++) begin
      peek(8'h10, da, sa, db, sb);
      chk("R10 busy window", da, 8'h01);
      @(negedge clk);
    end
    peek(8'h10, da, sa, db, sb);
    chk("R10 busy cleared", da, 8'h00);
    wr_port(8'h10, 8'h00);
    peek(8'h14, da, sa, db, sb);
    chk("R10 busy via primary", da, 8'h01);
  endtask

  task automatic t_base();
    logic [7:0] da, db;
    logic       sa, sb;
    wr_port(8'h31, 8'h77);
    wr_port(8'h38, 8'h42);
    @(negedge clk);
    peek(8'h35, da, sa, db, sb);
    chk("R11 b30 alias track", db, 8'h77);
    chk("R11 b30 card_sel", {7'd0, sb}, 8'h01);
    chk("R11 b10 ignores 35h", {7'd0, sa}, 8'h00);
    peek(8'h38, da, sa, db, sb);
    chk("R11 b30 drive", db, 8'h42);
    peek(8'h11, da, sa, db, sb);
    chk("R11 b30 ignores 11h", db, 8'hFF);
    chk("R11 b30 sel at 11h", {7'd0, sb}, 8'h00);
    chk("R11 b10 track kept", da, 8'hAA);
    peek(8'h18, da, sa, db, sb);
    chk("R11 b10 drive kept", da, 8'h81);
  endtask

  initial begin
    rst_n    = 1'b0;
    io_addr  = 8'h00;
    io_rd    = 1'b0;
    io_wr    = 1'b0;
    io_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_mirror();
    t_step();
    t_detect();
    t_drive();
    t_outside();
    t_busy();
    t_base();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule